// File: doc/BRIEF.md
# Set-Balancing Prefetch Address Remapper

This block sits between a prefetch address generator and the prefetch request port of a set-associative cache. It keeps one reference bit per cache set. A set's bit is raised whenever a demand access touches that set and whenever a prefetch is issued into it. Each candidate prefetch address is checked against this vector. If its set was already referenced, the set-index field is rewritten to the nearest set that has not been referenced yet. The aim is to spread prefetch fills evenly over all sets, so that the footprint of the demand stream cannot be read from which sets are occupied.

As soon as every set has been referenced, the vector clears itself and a new balancing round begins. The block also produces next-line candidates of its own. It counts demand misses, and a demand hit that arrives while that count is a multiple of the throttle period starts a short run of candidates for the lines after the hit line. These candidates go through the same remapping. External candidates have priority over the internally generated ones. The remapped address is registered, so each prefetch leaves one cycle after its candidate was accepted.

Top module: `prefetch_set_balancer`

## Requirements
- R1: After synchronous reset, pf_valid is low, every reference bit is clear, and the miss count is zero.
- R2: The set field is addr[OFF_W +: SET_W], with OFF_W = log2(LINE_BYTES) and SET_W = log2(NUM_SETS). With the defaults this is addr[5:4]. The bit of a set is raised by any demand access (hit or miss) to that set and by any prefetch issued into that set. When both occur in the same cycle, both bits are raised.
- R3: A candidate whose set bit is clear is issued with its address unchanged.
- R4: A candidate whose set bit is set gets its set field replaced by the nearest clear set. Distance is circular, and at equal distance set+k wins over set-k. Examples with the defaults: bits {s0=1,s1=0,s2=1,s3=0} turn 0x1080 into 0x1090 and 0x60A0 into 0x60B0; bits {1,1,1,0} turn 0x2080 into 0x20B0.
- R5: The bits above and below the set field pass through unchanged.
- R6: When the updates of a cycle leave every bit set, the whole vector is cleared at that edge.
- R7: Remapping uses the vector as registered before the current cycle's updates, so a same-cycle demand access to the candidate's set does not move that candidate.
- R8: Demand misses are counted modulo HIT_PERIOD (default 16). A demand hit seen while the count is 0 and no run is active starts a run of NL_DEGREE candidates (default 2): line-aligned hit address + i*LINE_BYTES for i = 1..NL_DEGREE, one per free cycle, beginning the cycle after the hit.
- R9: A demand hit while the miss count is nonzero produces no prefetch.
- R10: An external candidate takes precedence over a generated one; the generated run holds until a cycle without an external candidate.
- R11: Each accepted candidate yields exactly one pf_valid pulse with its address one clock later; no candidate gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | 1 | A demand access happens this cycle |
| dmd_hit | input | 1 | The demand access hit (1) or missed (0) |
| dmd_addr | input | ADDR_W | Demand access byte address |
| cand_valid | input | 1 | External prefetch candidate present |
| cand_addr | input | ADDR_W | External prefetch candidate byte address |
| pf_valid | output | 1 | Remapped prefetch issued |
| pf_addr | output | ADDR_W | Remapped prefetch byte address |

## Verification
Candidates are driven into free sets to show that they pass untouched. Others go into taken sets, with clear neighbours on one side only and on both sides, to separate the nearest-set search from its tie-break direction. Vectors are also steered to one short of full, to show that the self-clear happens on the filling edge, including when a demand access and a prefetch fill it together. Demand hits are issued at miss counts on and off a multiple of the period, which separates throttling from generation. A generated run is overlapped with an external candidate to expose the priority and the holding of the run.

// File: rtl/psb_pkg.sv
// Shared types for the set-balancing prefetch remapper.
// Assumes nothing beyond IEEE 1800-2017 enums.
package psb_pkg;

    // Which source feeds the remapper in a cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_GEN  = 2'd2
    } psb_src_e;

endpackage

// File: rtl/psb_remap.sv
// Combinational set-index rewrite.
// Finds the nearest clear set (circular distance, +k before -k) and places it
// in the set field; the other address bits pass through.
// Assumes NUM_SETS is a power of two and the vector is never all ones.
module psb_remap #(
    parameter int ADDR_W   = 32,
    parameter int NUM_SETS = 4,
    parameter int OFF_W    = 4,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [NUM_SETS-1:0] ref_vec,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [SET_W-1:0]    out_set
);

    logic [SET_W-1:0] home_set;
    logic [SET_W-1:0] pick;

    assign home_set = in_addr[OFF_W +: SET_W];

    // Priority search outward from the home set.
    always_comb begin
        logic             found;
        logic [SET_W-1:0] up_s;
        logic [SET_W-1:0] dn_s;
        found = 1'b0;
        pick  = home_set;
        for (int d = 0; d < NUM_SETS; d++) begin
            up_s = home_set + SET_W'(d);
            dn_s = home_set - SET_W'(d);
            if (!found && !ref_vec[up_s]) begin
                pick  = up_s;
                found = 1'b1;
            end else if (!found && !ref_vec[dn_s]) begin
                pick  = dn_s;
                found = 1'b1;
            end
        end
    end

    // Splice the chosen set into the address.
    always_comb begin
        out_addr                  = in_addr;
        out_addr[OFF_W +: SET_W]  = pick;
    end

    assign out_set = pick;

endmodule

// File: rtl/psb_refvec.sv
// Per-set reference bit vector.
// Raises bits for demand accesses and issued prefetches, then clears the
// whole vector when the result of a cycle would be all ones.
module psb_refvec #(
    parameter int NUM_SETS = 4,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dmd_mark,
    input  logic [SET_W-1:0]    dmd_set,
    input  logic                pf_mark,
    input  logic [SET_W-1:0]    pf_set,
    output logic [NUM_SETS-1:0] ref_q
);

    logic [NUM_SETS-1:0] ref_nxt;

    // Merge this cycle's marks, then apply the full-vector clear.
    always_comb begin
        ref_nxt = ref_q;
        if (dmd_mark) ref_nxt[dmd_set] = 1'b1;
        if (pf_mark)  ref_nxt[pf_set]  = 1'b1;
        if (&ref_nxt) ref_nxt = '0;
    end

    // Hold the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_nxt;
    end

endmodule

// File: rtl/psb_nextline.sv
// Throttled next-line candidate generator.
// Counts demand misses modulo HIT_PERIOD; a hit at count 0 with no run
// active starts NL_DEGREE candidates after the hit line. A candidate is
// consumed only when take is high. Assumes HIT_PERIOD is a power of two.
module psb_nextline #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 4,
    parameter int NL_DEGREE  = 2,
    parameter int HIT_PERIOD = 16,
    localparam int CNT_W     = $clog2(HIT_PERIOD),
    localparam int IDX_W     = $clog2(NL_DEGREE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_valid,
    input  logic              dmd_hit,
    input  logic [ADDR_W-1:0] dmd_addr,
    input  logic              take,
    output logic              gen_valid,
    output logic [ADDR_W-1:0] gen_addr
);

    logic [CNT_W-1:0]  miss_cnt;
    logic              busy;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  idx;
    logic              trigger;

    assign trigger   = dmd_valid && dmd_hit && (miss_cnt == '0) && !busy;
    assign gen_valid = busy;
    assign gen_addr  = base + (ADDR_W'(idx) << OFF_W);

    // Miss counter, wrapping at the period.
    always_ff @(posedge clk) begin
        if (!rst_n)                   miss_cnt <= '0;
        else if (dmd_valid && !dmd_hit) miss_cnt <= miss_cnt + 1'b1;
    end

    // Run control: start on trigger, step on take, stop after the last line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            base <= '0;
            idx  <= '0;
        end else if (trigger) begin
            busy <= 1'b1;
            base <= {dmd_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            idx  <= IDX_W'(1);
        end else if (busy && take) begin
            if (idx == IDX_W'(NL_DEGREE)) busy <= 1'b0;
            else                          idx  <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/prefetch_set_balancer.sv
// Top of the set-balancing prefetch remapper.
// Selects an external or generated candidate, remaps its set against the
// reference vector and registers the result (one-cycle latency).
// Assumes NUM_SETS >= 2, NUM_SETS, LINE_BYTES and HIT_PERIOD powers of two.
module prefetch_set_balancer
    import psb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_SETS   = 4,
    parameter int LINE_BYTES = 16,
    parameter int NL_DEGREE  = 2,
    parameter int HIT_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_valid,
    input  logic              dmd_hit,
    input  logic [ADDR_W-1:0] dmd_addr,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SET_W = $clog2(NUM_SETS);

    psb_src_e            src;
    logic                sel_valid;
    logic [ADDR_W-1:0]   sel_addr;
    logic                gen_valid;
    logic [ADDR_W-1:0]   gen_addr;
    logic                gen_take;
    logic [NUM_SETS-1:0] ref_q;
    logic [ADDR_W-1:0]   map_addr;
    logic [SET_W-1:0]    map_set;

    // Source choice: external candidates first.
    always_comb begin
        if (cand_valid)     src = SRC_EXT;
        else if (gen_valid) src = SRC_GEN;
        else                src = SRC_NONE;
    end

    // Candidate mux driven by the source choice.
    always_comb begin
        unique case (src)
            SRC_EXT: begin sel_valid = 1'b1; sel_addr = cand_addr; end
            SRC_GEN: begin sel_valid = 1'b1; sel_addr = gen_addr;  end
            default: begin sel_valid = 1'b0; sel_addr = cand_addr; end
        endcase
    end

    assign gen_take = (src == SRC_GEN);

    psb_nextline #(
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W),
        .NL_DEGREE  (NL_DEGREE),
        .HIT_PERIOD (HIT_PERIOD)
    ) u_nextline (
        .clk       (clk),
        .rst_n     (rst_n),
        .dmd_valid (dmd_valid),
        .dmd_hit   (dmd_hit),
        .dmd_addr  (dmd_addr),
        .take      (gen_take),
        .gen_valid (gen_valid),
        .gen_addr  (gen_addr)
    );

    psb_remap #(
        .ADDR_W   (ADDR_W),
        .NUM_SETS (NUM_SETS),
        .OFF_W    (OFF_W)
    ) u_remap (
        .in_addr  (sel_addr),
        .ref_vec  (ref_q),
        .out_addr (map_addr),
        .out_set  (map_set)
    );

    psb_refvec #(
        .NUM_SETS (NUM_SETS)
    ) u_refvec (
        .clk      (clk),
        .rst_n    (rst_n),
        .dmd_mark (dmd_valid),
        .dmd_set  (dmd_addr[OFF_W +: SET_W]),
        .pf_mark  (sel_valid),
        .pf_set   (map_set),
        .ref_q    (ref_q)
    );

    // Output register for the issued prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= sel_valid;
            pf_addr  <= map_addr;
        end
    end

endmodule

// File: rtl/psb_checker.sv
// Property checker for prefetch_set_balancer, attached by bind.
// Keeps its own one-cycle copies of the selected candidate and vector.
module psb_checker #(
    parameter int ADDR_W   = 32,
    parameter int NUM_SETS = 4,
    parameter int OFF_W    = 4,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pf_valid,
    input logic [ADDR_W-1:0]   pf_addr,
    input logic                sel_valid,
    input logic [ADDR_W-1:0]   sel_addr,
    input logic [NUM_SETS-1:0] ref_q
);

    logic                v_q;
    logic [ADDR_W-1:0]   a_q;
    logic [NUM_SETS-1:0] r_q;

    // Delay copies aligned with the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            a_q <= '0;
            r_q <= '0;
        end else begin
            v_q <= sel_valid;
            a_q <= sel_addr;
            r_q <= ref_q;
        end
    end

    AST_TARGET_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !r_q[pf_addr[OFF_W +: SET_W]]); // R4

    AST_FREE_SET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !r_q[a_q[OFF_W +: SET_W]]) |-> (pf_addr == a_q)); // R3

    AST_TAG_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[ADDR_W-1:OFF_W+SET_W] == a_q[ADDR_W-1:OFF_W+SET_W]
                      && pf_addr[OFF_W-1:0] == a_q[OFF_W-1:0])); // R5

    AST_VECTOR_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ref_q)); // R6

    AST_ONE_PULSE_PER_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid == v_q); // R11

endmodule

bind prefetch_set_balancer psb_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_SETS (NUM_SETS),
    .OFF_W    (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pf_valid  (pf_valid),
    .pf_addr   (pf_addr),
    .sel_valid (sel_valid),
    .sel_addr  (sel_addr),
    .ref_q     (ref_q)
);

// File: tb/prefetch_set_balancer_tb.sv
// Directed bench for prefetch_set_balancer with default parameters
// (4 sets, 16-byte lines, set field addr[5:4], 2 next lines, period 16).
module prefetch_set_balancer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dmd_valid = 1'b0;
    logic        dmd_hit = 1'b0;
    logic [31:0] dmd_addr = '0;
    logic        cand_valid = 1'b0;
    logic [31:0] cand_addr = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prefetch_set_balancer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dmd_valid  (dmd_valid),
        .dmd_hit    (dmd_hit),
        .dmd_addr   (dmd_addr),
        .cand_valid (cand_valid),
        .cand_addr  (cand_addr),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr)
    );

    // One clock with the given inputs; outputs are read 1 time unit after the edge.
    task automatic step(input logic dv, input logic dh, input logic [31:0] da,
                        input logic cv, input logic [31:0] ca);
        dmd_valid  = dv;
        dmd_hit    = dh;
        dmd_addr   = da;
        cand_valid = cv;
        cand_addr  = ca;
        @(posedge clk);
        #1;
        dmd_valid  = 1'b0;
        cand_valid = 1'b0;
    endtask

    task automatic expect_pf(input logic ev, input logic [31:0] ea, input string req);
        n_checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
                     req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    task automatic miss(input logic [31:0] a);
        step(1'b1, 1'b0, a, 1'b0, '0);
    endtask

    task automatic cand(input logic [31:0] a, input logic [31:0] ea, input string req);
        step(1'b0, 1'b0, '0, 1'b1, a);
        expect_pf(1'b1, ea, req);
    endtask

    task automatic idle_expect(input logic ev, input logic [31:0] ea, input string req);
        step(1'b0, 1'b0, '0, 1'b0, '0);
        expect_pf(ev, ea, req);
    endtask

    // R1: reset state
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        expect_pf(1'b0, '0, "R1 reset valid low");
    endtask

    // R2 R4 R5: taken set moves to nearest clear set, +1 wins the tie
    task automatic t_first_remap;
        miss(32'h0000_0000);                                  // set 0
        miss(32'h0000_0020);                                  // set 2 -> {1,0,1,0}
        cand(32'h0000_1080, 32'h0000_1090, "R4 tie picks set+1");
        cand(32'h0000_2080, 32'h0000_20B0, "R4 only set 3 clear");
        cand(32'h0000_3000, 32'h0000_3000, "R6 vector cleared after fill");
    endtask

    // R3 R6: free set passes, then fill clears
    task automatic t_free_pass;
        miss(32'h0000_0030);                                  // {1,0,0,1}
        miss(32'h0000_0010);                                  // {1,1,0,1}
        cand(32'h0000_20A0, 32'h0000_20A0, "R3 free set 2 unchanged");
        cand(32'h0000_4010, 32'h0000_4010, "R6 cleared, set 1 free");
    endtask

    // R4: tie from set 2 with both neighbours clear chooses set 3
    task automatic t_tie_up;
        cand(32'h0000_4020, 32'h0000_4020, "R3 set 2 free");
        cand(32'h0000_4030, 32'h0000_4030, "R3 set 3 free");
        cand(32'h0000_4000, 32'h0000_4000, "R3 set 0 free fills");
        miss(32'h0000_0000);
        miss(32'h0000_0020);                                  // {1,0,1,0}
        cand(32'h0000_60A4, 32'h0000_60B4, "R4 R5 set2 to set3 offset kept");
        cand(32'h0000_6000, 32'h0000_6010, "R4 set0 to set1");
    endtask

    // R7 R2 R6: same-cycle demand and prefetch
    task automatic t_same_cycle;
        step(1'b1, 1'b0, 32'h0000_0010, 1'b1, 32'h0000_7010);
        expect_pf(1'b1, 32'h0000_7010, "R7 same-cycle demand ignored by remap");
        cand(32'h0000_7010, 32'h0000_7020, "R2 set 1 now referenced");
        step(1'b1, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_7030);
        expect_pf(1'b1, 32'h0000_7030, "R3 set 3 free");
        cand(32'h0000_7000, 32'h0000_7000, "R6 joint fill cleared");
    endtask

    // R9 then R8: throttled next-line generation
    task automatic t_nextline;
        step(1'b1, 1'b1, 32'h0000_8000, 1'b0, '0);            // count 8
        expect_pf(1'b0, '0, "R9 hit off period");
        idle_expect(1'b0, '0, "R9 no next line");
        idle_expect(1'b0, '0, "R9 no next line");
        for (int i = 0; i < 8; i++) miss(32'h0000_0000);      // count 16 -> 0
        step(1'b1, 1'b1, 32'h0000_5004, 1'b0, '0);
        expect_pf(1'b0, '0, "R11 no pulse on hit cycle");
        idle_expect(1'b1, 32'h0000_5010, "R8 first next line");
        idle_expect(1'b1, 32'h0000_5020, "R8 second next line");
        idle_expect(1'b0, '0, "R8 run ends");
    endtask

    // R10: external candidate pre-empts a generated run
    task automatic t_priority;
        step(1'b1, 1'b1, 32'h0000_9010, 1'b0, '0);            // {1,1,1,0}
        expect_pf(1'b0, '0, "R11 no pulse on hit cycle");
        cand(32'h0000_A000, 32'h0000_A030, "R10 external first, R4 down side");
        idle_expect(1'b1, 32'h0000_9020, "R10 held run resumes");
        idle_expect(1'b1, 32'h0000_9030, "R8 run last line");
        idle_expect(1'b0, '0, "R11 idle");
    endtask

    initial begin
        t_reset();
        t_first_remap();
        t_free_pass();
        t_tie_up();
        t_same_cycle();
        t_nextline();
        t_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule